// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer on a small 32-bit register bus. A 16-bit counter counts upward once per prescaled tick while counting is enabled. When it wraps from all ones to zero, the block latches an overflow flag and drives a reset request pulse for a fixed number of clock cycles. Software arms a timeout of N ticks by loading the counter with 65536 minus N, then keeps the system alive by reloading it before it wraps.

Every register write must carry a key in its upper bits, so a runaway program that scribbles on the bus cannot stop or reload the watchdog by accident. A counter reload is not instant: a busy flag stays up while the new value moves into the counting logic, and software waits for it to drop before it turns counting on. The overflow flag is sticky. The block's own reset pulse does not clear it, so software that boots after a watchdog reset can read why it was reset.

The bus is a single-cycle write strobe with address and data. Read data is combinational from the address. Reset is an asynchronous, active-low power-on reset.

Top module: `wdt_keyed`

## Requirements
- R1: After power-on reset, the counter, control byte A, control byte B and the overflow flag all read 0, and the reset request output is low.
- R2: A write to offset 0x0 whose bits 31:16 equal 0x5A5A is accepted, and bits 15:0 become the new counter value. Reads of offset 0x0 return the counter in bits 15:0, with 0 in bits 31:16.
- R3: A write to offset 0x4 (control A) or offset 0x8 (control B) is accepted only when bits 31:8 equal 0xA5A5A5, and bits 7:0 carry the payload.
- R4: A write whose key does not match changes no register, flag or counter.
- R5: Control A bit 5 reads 1 for exactly 3 clock cycles after an accepted counter write, and the counter does not advance during that time. The new value is readable in the cycle the flag clears, and counting resumes from that value one cycle later.
- R6: Control A bits 2:0 select the tick divider: codes 0 to 7 give 1, 4, 16, 32, 64, 128, 1024 and 4096 clock cycles per count. A reload restarts the prescaler.
- R7: Control A bit 7 enables counting. With bit 7 at 0, the counter and prescaler hold their values, and the counter stays readable.
- R8: When the counter passes from 0xFFFF to 0x0000, control A bit 4 (overflow) is set. The reset request output rises in the same cycle the counter reads 0 and stays high for exactly 16 clock cycles.
- R9: The overflow flag stays set after the reset request pulse ends. A keyed control A write with bit 4 at 0 clears it. A write with bit 4 at 1 leaves it unchanged, so software cannot set it.
- R10: Control B holds the 8-bit payload of its last accepted write, and reads return it in bits 7:0.
- R11: Asserting the asynchronous reset at any time clears every register, including the overflow flag, and drops the reset request output at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| arst_ni | input | 1 | Asynchronous power-on reset, active low |
| bus_addr_i | input | 4 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data, including the key |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| rst_req_o | output | 1 | Reset request pulse raised on overflow |

## Verification
Several patterns exercise the counting path:
- **Divider codes:** six of the eight codes are run. The bench checks the count one cycle before and exactly at each expected tick, which separates a correct divider from one that is off by one cycle or uses the wrong code.
- **Reload while running:** the counter is reloaded while counting is enabled, and the bench compares counter values cycle by cycle across the busy window. This catches a busy window of the wrong length and a counter that keeps running during it.
- **Wrap from near the top:** a load close to 0xFFFF checks the wrap cycle and the pulse length. A later read of the flag shows that the end of the pulse does not clear it.
- **Stray writes:** each register is written with a wrong key, which shows that a bad key leaves everything untouched. A keyed write of a 1 to the flag shows that software cannot set it.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;

    localparam logic [15:0] CNT_KEY = 16'h5A5A;
    localparam logic [23:0] CTL_KEY = 24'hA5A5A5;

    typedef enum logic [1:0] {
        SEL_CNT  = 2'd0,
        SEL_CTLA = 2'd1,
        SEL_CTLB = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // clock cycles per count for each divider code
    function automatic int unsigned div_of(input logic [2:0] code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 4;
            3'd2:    return 16;
            3'd3:    return 32;
            3'd4:    return 64;
            3'd5:    return 128;
            3'd6:    return 1024;
            default: return 4096;
        endcase
    endfunction

endpackage

// File: rtl/wdt_key_check.sv
module wdt_key_check
    import wdt_keyed_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    input  logic              we_i,
    output reg_sel_e          sel_o,
    output logic              wr_cnt_o,
    output logic              wr_ctla_o,
    output logic              wr_ctlb_o
);

    logic cnt_key_ok;
    logic ctl_key_ok;

    always_comb begin
        if (addr_i == ADDR_W'(0))      sel_o = SEL_CNT;
        else if (addr_i == ADDR_W'(4)) sel_o = SEL_CTLA;
        else if (addr_i == ADDR_W'(8)) sel_o = SEL_CTLB;
        else                           sel_o = SEL_NONE;

        cnt_key_ok = (wdata_i[31:16] == CNT_KEY);
        ctl_key_ok = (wdata_i[31:8] == CTL_KEY);

        wr_cnt_o  = we_i && (sel_o == SEL_CNT)  && cnt_key_ok;
        wr_ctla_o = we_i && (sel_o == SEL_CTLA) && ctl_key_ok;
        wr_ctlb_o = we_i && (sel_o == SEL_CTLB) && ctl_key_ok;
    end

endmodule

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen
    import wdt_keyed_pkg::*;
#(
    parameter int PRE_W = 12
) (
    input  logic       clk_i,
    input  logic       arst_ni,
    input  logic       run_i,
    input  logic       clr_i,
    input  logic [2:0] code_i,
    output logic       tick_o
);

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] last;

    always_comb begin
        last   = PRE_W'(div_of(code_i) - 1);
        tick_o = run_i && (pre_q >= last);
        pre_d  = pre_q;
        if (clr_i)       pre_d = '0;
        else if (tick_o) pre_d = '0;
        else if (run_i)  pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) pre_q <= '0;
        else          pre_q <= pre_d;
    end

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
    import wdt_keyed_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CNT_W     = 16,
    parameter int PRE_W     = 12,
    parameter int BUSY_LEN  = 3,
    parameter int PULSE_LEN = 16
) (
    input  logic              clk_i,
    input  logic              arst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    input  logic              bus_we_i,
    output logic [31:0]       bus_rdata_o,
    output logic              rst_req_o
);

    localparam int BW = $clog2(BUSY_LEN + 1);
    localparam int PW = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] pend;
        logic             en;
        logic             ovf;
        logic [2:0]       code;
        logic [7:0]       ctlb;
        logic [BW-1:0]    busy;
        logic [PW-1:0]    pulse;
    } wdt_state_t;

    wdt_state_t state_d, state_q;

    reg_sel_e sel;
    logic     wr_cnt, wr_ctla, wr_ctlb;
    logic     tick, run, pre_clr, wrap;
    logic     busy_flag;

    wdt_key_check #(.ADDR_W(ADDR_W)) u_keys (
        .addr_i    (bus_addr_i),
        .wdata_i   (bus_wdata_i),
        .we_i      (bus_we_i),
        .sel_o     (sel),
        .wr_cnt_o  (wr_cnt),
        .wr_ctla_o (wr_ctla),
        .wr_ctlb_o (wr_ctlb)
    );

    assign busy_flag = (state_q.busy != '0);
    assign run       = state_q.en && !busy_flag;
    assign pre_clr   = (state_q.busy == BW'(1));

    wdt_tick_gen #(.PRE_W(PRE_W)) u_tick (
        .clk_i   (clk_i),
        .arst_ni (arst_ni),
        .run_i   (run),
        .clr_i   (pre_clr),
        .code_i  (state_q.code),
        .tick_o  (tick)
    );

    always_comb begin
        state_d = state_q;
        wrap    = 1'b0;

        if (state_q.pulse != '0) state_d.pulse = state_q.pulse - 1'b1;

        if (busy_flag) begin
            state_d.busy = state_q.busy - 1'b1;
            if (pre_clr) state_d.cnt = state_q.pend;
        end else if (tick) begin
            state_d.cnt = state_q.cnt + 1'b1;
            wrap        = (state_q.cnt == '1);
        end

        if (wr_cnt) begin
            state_d.pend = bus_wdata_i[CNT_W-1:0];
            state_d.busy = BW'(BUSY_LEN);
        end
        if (wr_ctla) begin
            state_d.en   = bus_wdata_i[7];
            state_d.code = bus_wdata_i[2:0];
            state_d.ovf  = state_q.ovf & bus_wdata_i[4];
        end
        if (wr_ctlb) state_d.ctlb = bus_wdata_i[7:0];

        if (wrap) begin
            state_d.ovf   = 1'b1;
            state_d.pulse = PW'(PULSE_LEN);
        end
    end

    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) state_q <= '0;
        else          state_q <= state_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        case (sel)
            SEL_CNT:  bus_rdata_o[CNT_W-1:0] = state_q.cnt;
            SEL_CTLA: bus_rdata_o[7:0] = {state_q.en, 1'b0, busy_flag, state_q.ovf,
                                          1'b0, state_q.code};
            SEL_CTLB: bus_rdata_o[7:0] = state_q.ctlb;
            default:  bus_rdata_o = '0;
        endcase
    end

    assign rst_req_o = (state_q.pulse != '0);

endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
    parameter int ADDR_W    = 4,
    parameter int CNT_W     = 16,
    parameter int PULSE_LEN = 16
) (
    input logic              clk_i,
    input logic              arst_ni,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [31:0]       bus_wdata_i,
    input logic              bus_we_i,
    input logic              rst_req_o,
    input logic [CNT_W-1:0]  cnt_i,
    input logic [CNT_W-1:0]  pend_i,
    input logic              en_i,
    input logic              ovf_i,
    input logic              busy_i
);

    logic [15:0] hi_q;

    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni)       hi_q <= '0;
        else if (rst_req_o) hi_q <= hi_q + 1'b1;
        else                hi_q <= '0;
    end

    p_busy_needs_key_r2: assert property (@(posedge clk_i) disable iff (!arst_ni)
        $rose(busy_i) |-> $past(bus_we_i && bus_addr_i == ADDR_W'(0)
                                && bus_wdata_i[31:16] == 16'h5A5A));

    p_load_on_idle_r5: assert property (@(posedge clk_i) disable iff (!arst_ni)
        $fell(busy_i) |-> cnt_i == $past(pend_i));

    p_hold_when_off_r7: assert property (@(posedge clk_i) disable iff (!arst_ni)
        (!en_i && !busy_i) |=> $stable(cnt_i));

    p_pulse_at_zero_r8: assert property (@(posedge clk_i) disable iff (!arst_ni)
        $rose(rst_req_o) |-> (cnt_i == '0) && ovf_i);

    p_pulse_length_r8: assert property (@(posedge clk_i) disable iff (!arst_ni)
        $fell(rst_req_o) |-> hi_q >= 16'(PULSE_LEN));

    p_ovf_clear_by_write_r9: assert property (@(posedge clk_i) disable iff (!arst_ni)
        $fell(ovf_i) |-> $past(bus_we_i && bus_addr_i == ADDR_W'(4)
                               && bus_wdata_i[31:8] == 24'hA5A5A5 && !bus_wdata_i[4]));

endmodule

bind wdt_keyed wdt_keyed_chk #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)
) u_chk (
    .clk_i       (clk_i),
    .arst_ni     (arst_ni),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_we_i    (bus_we_i),
    .rst_req_o   (rst_req_o),
    .cnt_i       (state_q.cnt),
    .pend_i      (state_q.pend),
    .en_i        (state_q.en),
    .ovf_i       (state_q.ovf),
    .busy_i      (busy_flag)
);

// File: tb/test_wdt_keyed.sv
module test_wdt_keyed;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        arst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic [31:0] rdata;
    logic        rst_req;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_keyed i_wdt_keyed (
        .clk_i       (clk),
        .arst_ni     (arst_n),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_we_i    (we),
        .bus_rdata_o (rdata),
        .rst_req_o   (rst_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(4'h0, v); check("R1 counter", v, 32'h0);
        rd(4'h4, v); check("R1 ctl A", v, 32'h0);
        rd(4'h8, v); check("R1 ctl B", v, 32'h0);
        check("R1 rst_req", {31'b0, rst_req}, 32'h0);
    endtask

    task automatic t_bad_keys();
        logic [31:0] v;
        wr(4'h0, 32'h12340055);
        idle(4);
        rd(4'h0, v); check("R4 counter bad key", v, 32'h0);
        rd(4'h4, v); check("R4 no busy after bad key", v, 32'h0);
        wr(4'h4, 32'hA5A5A400 | 32'h87);
        rd(4'h4, v); check("R4 ctl A bad key", v, 32'h0);
        wr(4'h8, 32'h5A5A5A3C);
        rd(4'h8, v); check("R4 ctl B bad key", v, 32'h0);
    endtask

    task automatic t_busy();
        logic [31:0] v;
        wr(4'h0, 32'h5A5A1234);
        rd(4'h4, v); check("R5 busy cycle 1", v, 32'h20);
        rd(4'h0, v); check("R5 old value while busy", v, 32'h0);
        idle(1); rd(4'h4, v); check("R5 busy cycle 2", v, 32'h20);
        idle(1); rd(4'h4, v); check("R5 busy cycle 3", v, 32'h20);
        idle(1); rd(4'h4, v); check("R5 busy cleared", v, 32'h0);
        rd(4'h0, v); check("R2 loaded value", v, 32'h1234);
    endtask

    task automatic t_count_and_reload();
        logic [31:0] v, a;
        wr(4'h4, 32'hA5A5A580);
        rd(4'h0, v); check("R7 enabled, no tick yet", v, 32'h1234);
        idle(10);
        rd(4'h0, v); check("R6 code 0 counts every cycle", v, 32'h123E);
        wr(4'h0, 32'h5A5A0050);
        rd(4'h0, a);
        idle(1); rd(4'h0, v); check("R5 paused while busy 1", v, a);
        idle(1); rd(4'h0, v); check("R5 paused while busy 2", v, a);
        idle(1); rd(4'h0, v); check("R5 new value at clear", v, 32'h50);
        idle(1); rd(4'h0, v); check("R5 resumes after load", v, 32'h51);
    endtask

    task automatic t_freeze();
        logic [31:0] v, a;
        wr(4'h4, 32'hA5A5A500);
        rd(4'h0, a);
        idle(20);
        rd(4'h0, v); check("R7 counter frozen", v, a);
        check("R2 upper read bits zero", {16'h0, v[31:16]}, 32'h0);
    endtask

    task automatic t_div(input logic [2:0] code, input int div);
        logic [31:0] v;
        wr(4'h4, 32'hA5A5A500);
        wr(4'h0, 32'h5A5A0200);
        idle(3);
        wr(4'h4, 32'hA5A5A580 | {29'b0, code});
        idle(3 * div - 1);
        rd(4'h0, v); check($sformatf("R6 code %0d before tick", code), v, 32'h202);
        idle(1);
        rd(4'h0, v); check($sformatf("R6 code %0d at tick", code), v, 32'h203);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        int hi;
        wr(4'h4, 32'hA5A5A500);
        wr(4'h0, 32'h5A5AFFFD);
        idle(3);
        wr(4'h4, 32'hA5A5A580);
        idle(2);
        rd(4'h0, v); check("R8 at top", v, 32'hFFFF);
        check("R8 no pulse before wrap", {31'b0, rst_req}, 32'h0);
        idle(1);
        rd(4'h0, v); check("R8 wrapped to zero", v, 32'h0);
        rd(4'h4, v); check("R8 overflow flag set", v, 32'h90);
        hi = 0;
        for (int i = 0; i < 40; i++) begin
            if (rst_req) hi++;
            @(negedge clk);
        end
        check("R8 pulse length", hi, 16);
        rd(4'h4, v); check("R9 flag survives pulse", v, 32'h90);
    endtask

    task automatic t_sticky();
        logic [31:0] v;
        wr(4'h4, 32'hA5A5A510);
        rd(4'h4, v); check("R9 writing 1 keeps flag", v, 32'h10);
        wr(4'h4, 32'h12A5A500);
        rd(4'h4, v); check("R4 bad key keeps flag", v, 32'h10);
        wr(4'h4, 32'hA5A5A500);
        rd(4'h4, v); check("R9 keyed 0 clears flag", v, 32'h0);
        wr(4'h4, 32'hA5A5A510);
        rd(4'h4, v); check("R9 software cannot set flag", v, 32'h0);
    endtask

    task automatic t_ctlb();
        logic [31:0] v;
        wr(4'h8, 32'hA5A5A53C);
        rd(4'h8, v); check("R10 ctl B stored", v, 32'h3C);
        wr(4'h8, 32'hA5A5B5C3);
        rd(4'h8, v); check("R3 ctl B wrong key ignored", v, 32'h3C);
    endtask

    task automatic t_async();
        logic [31:0] v;
        wr(4'h0, 32'h5A5AFFFF);
        idle(3);
        wr(4'h4, 32'hA5A5A580);
        idle(1);
        check("R8 pulse before async reset", {31'b0, rst_req}, 32'h1);
        #2 arst_n = 1'b0;
        #1;
        check("R11 pulse dropped", {31'b0, rst_req}, 32'h0);
        rd(4'h4, v); check("R11 flag cleared", v, 32'h0);
        rd(4'h0, v); check("R11 counter cleared", v, 32'h0);
        rd(4'h8, v); check("R11 ctl B cleared", v, 32'h0);
        @(negedge clk);
        arst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        arst_n = 1'b1;
        idle(1);
        t_reset();
        t_bad_keys();
        t_busy();
        t_count_and_reload();
        t_freeze();
        t_div(3'd0, 1);
        t_div(3'd1, 4);
        t_div(3'd2, 16);
        t_div(3'd5, 128);
        t_div(3'd6, 1024);
        t_div(3'd7, 4096);
        t_overflow();
        t_sticky();
        t_ctlb();
        t_async();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule